// File: doc/BRIEF.md
# Virtually Tagged Set-Associative Cache with Address-Space Tags

This block is a set-associative cache lookup stage that works entirely on virtual addresses. Both the set index and the tag come straight from the request address, so no translation stands in front of the lookup. Address translation happens elsewhere, and only after a miss. Every line records the address-space identifier of the process that filled it. A lookup hits only when that identifier equals the current one, which stops one process from hitting on another process's line at the same virtual address. A line can instead be marked global; it then hits under any identifier.

Two maintenance sequences share one walker, which visits one set per clock and holds `busy` high while it runs. The full flush clears every line. It is used when identifier checking is switched off and the context changes. The page invalidate clears the lines whose virtual tag matches a given page and whose owner matches the current identifier, or that are global. It is used when a page is remapped. While `busy` is high, lookups, refills and further invalidates are held off. A new flush restarts the walk from the first set.

Refill is a one-word write port. The caller chooses the way. The write sets the line's tag, owner identifier, global flag and valid bit.

Top module: `vtag_cache`

## Requirements
- R1: A lookup accepted at a clock edge (`req_valid` high, `busy` low) yields exactly one of `hit` or `miss` for the one following cycle. When there is no accepted lookup, both stay low, including right after reset.
- R2: On a hit, `rd_data` returns the last word refilled at the same set, way and word offset. On a miss, `rd_data` is zero.
- R3: With `asid_en` high, a non-global line hits only when its stored identifier equals `cur_asid`.
- R4: A line refilled with `fill_global` high hits under every value of `cur_asid`.
- R5: With `asid_en` low, a tag match on a valid line is enough to hit, whatever its owner identifier.
- R6: A `flush_req` raises `busy` for exactly SETS cycles. Afterwards, every lookup misses.
- R7: While `busy` is high, a lookup produces neither `hit` nor `miss`, and a refill leaves no line behind.
- R8: A `flush_req` that arrives while a walk is running restarts the walk at set 0. `busy` then stays high for SETS more cycles.
- R9: A page invalidate keeps `busy` high for SETS cycles. It removes the lines whose tag equals `inv_va[ADDR_W-1:ADDR_W-TAG_W]` and that are global, owned by `cur_asid`, or checked with `asid_en` low. All other lines stay.
- R10: An `inv_req` during a running walk is ignored. A `flush_req` during an invalidate takes over as a full flush.
- R11: The address is split as word offset = bits above the byte offset within a data word, set index = the IDX_W bits above the line offset, and tag = the remaining upper bits. A tag absent from a set misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_asid | input | ASID_W | Identifier of the running address space |
| asid_en | input | 1 | Enables the identifier comparison |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | ADDR_W | Lookup virtual address |
| fill_valid | input | 1 | Refill write strobe |
| fill_way | input | log2(WAYS) | Way to write |
| fill_va | input | ADDR_W | Virtual address of the refilled word |
| fill_data | input | DATA_W | Refill word |
| fill_global | input | 1 | Marks the line global |
| flush_req | input | 1 | Starts (or restarts) a full flush |
| inv_req | input | 1 | Starts a page invalidate |
| inv_va | input | ADDR_W | Any address inside the page to invalidate |
| busy | output | 1 | A maintenance walk is running |
| hit | output | 1 | Lookup result: hit |
| miss | output | 1 | Lookup result: miss |
| rd_data | output | DATA_W | Data word of a hit |

## Verification
The bench builds the cache with 4 sets, 2 ways, 16-byte lines, 32-bit words and 2-bit identifiers. At that size, every set, way, word offset, identifier value and `asid_en` setting can be swept in one run. Each walk takes only 4 cycles, so the exact length of `busy`, a restart in the middle of a walk, and a command arriving mid-walk can each be counted cycle by cycle. Page invalidates are then checked against every line for each identifier.

// File: rtl/vtc_pkg.sv
// Shared types of the virtually tagged cache.
package vtc_pkg;
    // What the maintenance walker is currently doing.
    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_FLUSH = 2'd1,
        WALK_INV   = 2'd2
    } walk_e;
endpackage

// File: rtl/vtc_walker.sv
// Maintenance walker: steps through the sets one per clock for a full
// flush or a page invalidate. Assumes SETS is a power of two.
// A flush command always (re)starts at set 0; an invalidate only starts
// from idle.
module vtc_walker
    import vtc_pkg::*;
#(
    parameter int SETS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_cmd,
    input  logic                    inv_cmd,
    output logic                    busy,
    output logic [$clog2(SETS)-1:0] walk_idx,
    output walk_e                   mode
);
    localparam int IDX_W = $clog2(SETS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

    walk_e            mode_q;
    logic [IDX_W-1:0] cnt_q;

    // Mode and set counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WALK_IDLE;
            cnt_q  <= '0;
        end else if (flush_cmd) begin
            mode_q <= WALK_FLUSH;
            cnt_q  <= '0;
        end else if (inv_cmd && mode_q == WALK_IDLE) begin
            mode_q <= WALK_INV;
            cnt_q  <= '0;
        end else if (mode_q != WALK_IDLE) begin
            if (cnt_q == LAST) mode_q <= WALK_IDLE;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy     = (mode_q != WALK_IDLE);
    assign walk_idx = cnt_q;
    assign mode     = mode_q;

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && flush_cmd) |=> (busy && walk_idx == '0));

    // R10
    inv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && inv_cmd && !flush_cmd && walk_idx != LAST)
            |=> (busy && walk_idx == $past(walk_idx) + 1'b1));
endmodule

// File: rtl/vtc_tag_store.sv
// Tag store: per line a valid bit, virtual tag, owner identifier and
// global flag. Provides the per-way hit vector for a lookup, a refill
// write, and the per-set clear used by the walker. Assumes refill and
// walk never coincide (the top blocks refill while busy).
module vtc_tag_store #(
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] lk_idx,
    input  logic [TAG_W-1:0]        lk_tag,
    input  logic [ASID_W-1:0]       cur_asid,
    input  logic                    asid_en,
    output logic [WAYS-1:0]         hit_vec,
    input  logic                    fill_we,
    input  logic [$clog2(WAYS)-1:0] fill_way,
    input  logic [$clog2(SETS)-1:0] fill_idx,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic                    fill_glob,
    input  logic                    walk_clr,
    input  logic                    walk_inv,
    input  logic [$clog2(SETS)-1:0] walk_idx,
    input  logic [TAG_W-1:0]        inv_tag,
    input  logic [ASID_W-1:0]       inv_asid,
    input  logic                    inv_asid_en,
    output logic [SETS*WAYS-1:0]    valid_bits
);
    logic [WAYS-1:0]   vld_q  [SETS];
    logic [WAYS-1:0]   glob_q [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [ASID_W-1:0] asid_q [SETS][WAYS];
    logic [WAYS-1:0]   clr_mask;

    // Per-way lookup compare and walk clear mask.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag)
                         && (glob_q[lk_idx][w] || !asid_en
                             || asid_q[lk_idx][w] == cur_asid);
        assign clr_mask[w] = !walk_inv
                          || ((tag_q[walk_idx][w] == inv_tag)
                              && (glob_q[walk_idx][w] || !inv_asid_en
                                  || asid_q[walk_idx][w] == inv_asid));
    end

    // Valid bits: reset, set on refill, cleared by the walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else begin
            if (walk_clr) vld_q[walk_idx] <= vld_q[walk_idx] & ~clr_mask;
            if (fill_we)  vld_q[fill_idx][fill_way] <= 1'b1;
        end
    end

    // Line attributes, written on refill only.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[fill_idx][fill_way]  <= fill_tag;
            asid_q[fill_idx][fill_way] <= cur_asid;
            glob_q[fill_idx][fill_way] <= fill_glob;
        end
    end

    // Flattened valid bits for the top-level checks.
    always_comb begin
        for (int s = 0; s < SETS; s++) valid_bits[s*WAYS +: WAYS] = vld_q[s];
    end
endmodule

// File: rtl/vtc_data_store.sv
// Data store: one word per (set, way, word offset), written by refill and
// read combinationally by the lookup. Assumes all counts are powers of two.
module vtc_data_store #(
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int WORDS  = 8,
    parameter int DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(SETS)-1:0]  w_idx,
    input  logic [$clog2(WAYS)-1:0]  w_way,
    input  logic [$clog2(WORDS)-1:0] w_word,
    input  logic [DATA_W-1:0]        w_data,
    input  logic [$clog2(SETS)-1:0]  r_idx,
    input  logic [$clog2(WAYS)-1:0]  r_way,
    input  logic [$clog2(WORDS)-1:0] r_word,
    output logic [DATA_W-1:0]        r_data
);
    localparam int DEPTH = SETS * WAYS * WORDS;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Refill write port.
    always_ff @(posedge clk) begin
        if (we) mem_q[{w_idx, w_way, w_word}] <= w_data;
    end

    assign r_data = mem_q[{r_idx, r_way, r_word}];
endmodule

// File: rtl/vtag_cache.sv
// Virtually indexed, virtually tagged cache with per-line address-space
// tags. Lookups give a registered hit/miss one cycle after acceptance.
// Requests, refills and invalidates are held off while the walker runs.
// Assumes SETS, WAYS, LINE_BYTES and DATA_W/8 are powers of two, WAYS >= 2.
module vtag_cache
    import vtc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ASID_W     = 8,
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 64,
    parameter int DATA_W     = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ASID_W-1:0]       cur_asid,
    input  logic                    asid_en,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_va,
    input  logic                    fill_valid,
    input  logic [$clog2(WAYS)-1:0] fill_way,
    input  logic [ADDR_W-1:0]       fill_va,
    input  logic [DATA_W-1:0]       fill_data,
    input  logic                    fill_global,
    input  logic                    flush_req,
    input  logic                    inv_req,
    input  logic [ADDR_W-1:0]       inv_va,
    output logic                    busy,
    output logic                    hit,
    output logic                    miss,
    output logic [DATA_W-1:0]       rd_data
);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int WORD_LO = $clog2(DATA_W / 8);
    localparam int WORDS   = LINE_BYTES / (DATA_W / 8);
    localparam int WORD_W  = $clog2(WORDS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int RUN_W   = IDX_W + 1;

    walk_e             walk_mode;
    logic [IDX_W-1:0]  walk_idx;
    logic [WAYS-1:0]   hit_vec;
    logic [WAY_W-1:0]  hit_way;
    logic [DATA_W-1:0] word_rd;
    logic [SETS*WAYS-1:0] valid_bits;
    logic [TAG_W-1:0]  inv_tag_q;
    logic [ASID_W-1:0] inv_asid_q;
    logic              inv_aen_q;

    wire accept    = req_valid && !busy;
    wire fill_we   = fill_valid && !busy;
    wire start_inv = inv_req && !flush_req && !busy;
    wire unused_lo = ^{req_va[WORD_LO-1:0], fill_va[WORD_LO-1:0],
                       inv_va[ADDR_W-TAG_W-1:0]};

    vtc_walker #(.SETS(SETS)) u_walk (
        .clk(clk), .rst_n(rst_n), .flush_cmd(flush_req), .inv_cmd(inv_req),
        .busy(busy), .walk_idx(walk_idx), .mode(walk_mode)
    );

    vtc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(req_va[OFF_W +: IDX_W]), .lk_tag(req_va[ADDR_W-1 -: TAG_W]),
        .cur_asid(cur_asid), .asid_en(asid_en), .hit_vec(hit_vec),
        .fill_we(fill_we), .fill_way(fill_way),
        .fill_idx(fill_va[OFF_W +: IDX_W]), .fill_tag(fill_va[ADDR_W-1 -: TAG_W]),
        .fill_glob(fill_global),
        .walk_clr(busy), .walk_inv(walk_mode == WALK_INV), .walk_idx(walk_idx),
        .inv_tag(inv_tag_q), .inv_asid(inv_asid_q), .inv_asid_en(inv_aen_q),
        .valid_bits(valid_bits)
    );

    vtc_data_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .we(fill_we),
        .w_idx(fill_va[OFF_W +: IDX_W]), .w_way(fill_way),
        .w_word(fill_va[WORD_LO +: WORD_W]), .w_data(fill_data),
        .r_idx(req_va[OFF_W +: IDX_W]), .r_way(hit_way),
        .r_word(req_va[WORD_LO +: WORD_W]), .r_data(word_rd)
    );

    // Lowest hitting way selects the data word.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    // Capture the page and owner of an invalidate when it starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_tag_q  <= '0;
            inv_asid_q <= '0;
            inv_aen_q  <= 1'b0;
        end else if (start_inv) begin
            inv_tag_q  <= inv_va[ADDR_W-1 -: TAG_W];
            inv_asid_q <= cur_asid;
            inv_aen_q  <= asid_en;
        end
    end

    // Registered lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            miss    <= 1'b0;
            rd_data <= '0;
        end else begin
            hit     <= accept && (|hit_vec);
            miss    <= accept && !(|hit_vec);
            rd_data <= (accept && (|hit_vec)) ? word_rd : '0;
        end
    end

    // Check-only state: busy cycles since the last command, and its kind.
    logic [RUN_W-1:0] run_q;
    logic             last_flush_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q        <= '0;
            last_flush_q <= 1'b0;
        end else begin
            if (flush_req || start_inv) run_q <= '0;
            else if (busy)              run_q <= run_q + 1'b1;
            if (flush_req)      last_flush_q <= 1'b1;
            else if (start_inv) last_flush_q <= 1'b0;
        end
    end

    // R1
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));

    // R7
    quiet_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit || miss) |-> ($past(req_valid) && !$past(busy)));

    // R6
    walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(SETS)));

    // R6
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && last_flush_q) |-> (valid_bits == '0));
endmodule

// File: tb/sim_vtag_cache.sv
// Bench: small configuration, sweeps every line against a model of the
// requirements kept in the bench.
module sim_vtag_cache;
    localparam int ADDR_W = 32, ASID_W = 2, SETS = 4, WAYS = 2;
    localparam int LINE_BYTES = 16, DATA_W = 32, WORDS = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [ASID_W-1:0] cur_asid = '0;
    logic asid_en = 1'b1, req_valid = 1'b0, fill_valid = 1'b0, fill_global = 1'b0;
    logic flush_req = 1'b0, inv_req = 1'b0;
    logic [0:0] fill_way = '0;
    logic [ADDR_W-1:0] req_va = '0, fill_va = '0, inv_va = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic busy, hit, miss;
    logic [DATA_W-1:0] rd_data;

    int checks = 0, errors = 0;
    bit done = 0;
    bit m_vld [SETS][WAYS];
    bit m_glob [SETS][WAYS];
    int m_tag [SETS][WAYS];
    int m_asid [SETS][WAYS];
    int m_dat [SETS][WAYS][WORDS];

    always #5 clk = ~clk;

    vtag_cache #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .SETS(SETS), .WAYS(WAYS),
                 .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .asid_en(asid_en),
        .req_valid(req_valid), .req_va(req_va), .fill_valid(fill_valid),
        .fill_way(fill_way), .fill_va(fill_va), .fill_data(fill_data),
        .fill_global(fill_global), .flush_req(flush_req), .inv_req(inv_req),
        .inv_va(inv_va), .busy(busy), .hit(hit), .miss(miss), .rd_data(rd_data)
    );

    function automatic logic [ADDR_W-1:0] mk_va(int tg, int s, int k);
        return ADDR_W'((tg << 6) | (s << 4) | (k << 2));
    endfunction

    function automatic int m_find(int tg, int s, int a, bit aen);
        for (int w = 0; w < WAYS; w++)
            if (m_vld[s][w] && m_tag[s][w] == tg && (m_glob[s][w] || !aen || m_asid[s][w] == a))
                return w;
        return -1;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(int w, int tg, int s, int k, int a, bit g, int d);
        @(negedge clk);
        fill_valid = 1; fill_way = 1'(w); fill_va = mk_va(tg, s, k);
        fill_data = DATA_W'(d); fill_global = g; cur_asid = ASID_W'(a);
        @(negedge clk);
        fill_valid = 0;
        m_vld[s][w] = 1; m_tag[s][w] = tg; m_asid[s][w] = a; m_glob[s][w] = g;
        m_dat[s][w][k] = d;
    endtask

    task automatic look(int tg, int s, int k, int a, bit aen, string req);
        int w;
        @(negedge clk);
        req_valid = 1; req_va = mk_va(tg, s, k); cur_asid = ASID_W'(a); asid_en = aen;
        @(negedge clk);
        req_valid = 0;
        w = m_find(tg, s, a, aen);
        if (w >= 0)
            chk(hit && !miss && rd_data == DATA_W'(m_dat[s][w][k]), req,
                {hit, miss, rd_data}, {2'b10, DATA_W'(m_dat[s][w][k])});
        else
            chk(!hit && miss && rd_data == 0, req, {hit, miss, rd_data}, {2'b01, 32'h0});
    endtask

    // Compare every line of tags 1..7 against the model.
    task automatic sweep_all();
        for (int tg = 1; tg < 8; tg++)
            for (int s = 0; s < SETS; s++)
                for (int a = 0; a < 4; a++)
                    for (int e = 0; e < 2; e++) begin
                        int w;
                        string r;
                        w = m_find(tg, s, a, e[0]);
                        r = (w >= 0 && m_glob[s][w]) ? "R4" : (e == 0) ? "R5" :
                            (w < 0) ? "R3" : "R2";
                        look(tg, s, (s + tg) % WORDS, a, e[0], r);
                    end
    endtask

    // Pulse a command and count the cycles busy stays high.
    task automatic walk_cmd(bit fl, int tg, int a, bit aen, output int n);
        @(negedge clk);
        flush_req = fl; inv_req = !fl; inv_va = mk_va(tg, 0, 0);
        cur_asid = ASID_W'(a); asid_en = aen;
        @(negedge clk);
        flush_req = 0; inv_req = 0; n = 0;
        while (busy) begin n++; @(negedge clk); end
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                if (fl || (m_tag[s][w] == tg && (m_glob[s][w] || !aen || m_asid[s][w] == a)))
                    m_vld[s][w] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: quiet after reset
        chk(!hit && !miss && !busy, "R1", {hit, miss, busy}, 0);

        // R2 R11: fill every word of every line, sets own different owners
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                for (int k = 0; k < WORDS; k++)
                    fill(w, w + 1, s, k, s, (s == 3 && w == 1), 'hA000_0000 | (s << 8) | (w << 4) | k);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                for (int k = 0; k < WORDS; k++)
                    for (int a = 0; a < 4; a++)
                        for (int e = 0; e < 2; e++) begin
                            int fw;
                            fw = m_find(w + 1, s, a, e[0]);
                            look(w + 1, s, k, a, e[0],
                                 (fw >= 0 && m_glob[s][fw]) ? "R4" : (e == 0) ? "R5" :
                                 (fw < 0) ? "R3" : "R2");
                        end
        look(3, 1, 0, 1, 1, "R11");
        @(negedge clk);
        chk(!hit && !miss, "R1", {hit, miss}, 0);

        // R6: flush length and result
        walk_cmd(1, 0, 0, 1, n);
        chk(n == SETS, "R6", n, SETS);
        sweep_all();

        // R7: lookup and refill during a flush are ignored
        fill(0, 4, 2, 1, 0, 0, 'h55);
        @(negedge clk); flush_req = 1;
        @(negedge clk); flush_req = 0;
        req_valid = 1; req_va = mk_va(4, 2, 1); cur_asid = 0; asid_en = 1;
        fill_valid = 1; fill_way = 1; fill_va = mk_va(5, 0, 0); fill_data = 'h77;
        @(negedge clk);
        req_valid = 0; fill_valid = 0;
        chk(!hit && !miss, "R7", {hit, miss}, 0);
        while (busy) @(negedge clk);
        m_vld[2][0] = 0;
        look(5, 0, 0, 0, 1, "R7");
        look(4, 2, 1, 0, 1, "R6");

        // R8: flush restarted mid-walk
        @(negedge clk); flush_req = 1;
        @(negedge clk); flush_req = 0; n = 1;
        @(negedge clk); n++; flush_req = 1;
        @(negedge clk); flush_req = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(n == 2 + SETS, "R8", n, 2 + SETS);

        // R9: page invalidate by owner, global and disabled check
        fill(0, 5, 0, 0, 1, 0, 'h10);
        fill(1, 5, 0, 1, 2, 0, 'h11);
        fill(0, 5, 1, 2, 2, 0, 'h12);
        fill(0, 5, 2, 3, 3, 1, 'h13);
        fill(0, 6, 3, 0, 1, 0, 'h14);
        fill(1, 7, 3, 1, 1, 1, 'h15);
        walk_cmd(0, 5, 1, 1, n);
        chk(n == SETS, "R9", n, SETS);
        sweep_all();
        walk_cmd(0, 5, 0, 0, n);
        chk(n == SETS, "R9", n, SETS);
        sweep_all();

        // R10: invalidate during an invalidate is ignored
        @(negedge clk); inv_req = 1; inv_va = mk_va(2, 0, 0); cur_asid = 1; asid_en = 1;
        @(negedge clk); inv_req = 0; n = 1;
        @(negedge clk); n++; inv_req = 1; inv_va = mk_va(6, 0, 0);
        @(negedge clk); inv_req = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(n == SETS, "R10", n, SETS);
        look(6, 3, 0, 1, 1, "R10");

        // R10: flush during an invalidate takes over
        @(negedge clk); inv_req = 1; inv_va = mk_va(2, 0, 0);
        @(negedge clk); inv_req = 0; n = 1;
        @(negedge clk); n++; flush_req = 1;
        @(negedge clk); flush_req = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(n == 2 + SETS, "R10", n, 2 + SETS);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_vld[s][w] = 0;
        sweep_all();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule